// File: doc/BRIEF.md
# Static Frequency Readout Driver

This block turns a tuned-frequency result, delivered as a word of BCD digits, into the drive for a directly wired (non-multiplexed) seven-segment LED readout. Every lit segment is driven without interruption, so there is no scan clock and no digit strobing. The readout consists of three full seven-segment digits, a reduced leading position that can only show "1", a reduced trailing position that can only show "0" or "5", a decimal point, and two unit lamps for MHz and kHz.

A result word is accepted over a valid/ready stream port. It is stored together with its band code and resolution flag, and the readout is decoded from that store on every cycle. The band decides how many positions light and which BCD digit feeds each one. An active-low freeze input holds the readout by refusing new words. A blanking input darkens everything without touching the store, which keeps garbage off the readout during power-up.

Back-pressure rules: `in_ready` equals `freeze_n`. A producer keeps `in_valid` and its payload steady until a cycle with both high. No word is dropped. A word offered while frozen waits and is taken on the first clock edge after the freeze ends.

Top module: `led_disp`

## Requirements
- R1: After reset, and until the first word is taken, every active-low output is high (dark). `in_ready` follows `freeze_n` even during reset.
- R2: A word is taken on a rising clock edge where `in_valid` and `in_ready` are both high, and the readout shows it from that edge on. `in_ready` is high exactly when `freeze_n` is high.
- R3: While `freeze_n` is low, no word is taken, and the readout stays unchanged for as long as `blank` does not change.
- R4: While `blank` is high, every output except `in_ready` is high. The stored word is kept, and the same readout returns once `blank` falls.
- R5: Each full digit `seg_n[7*i+6 : 7*i]` is ordered {g,f,e,d,c,b,a}, active low, and uses the usual patterns for 0 to 9 (active-high hex 3F,06,5B,4F,66,6D,7D,07,7F,6F). A code from 10 to 15 leaves the digit dark.
- R6: Band code 0 (FM) feeds full digits 2,1,0 from BCD digits 3,2,1 (BCD digit k is `in_bcd[4k+3:4k]`). It also lights `dp_n` (format XXX.XX) and `mhz_n`.
- R7: In FM, the trailing position `tail_n` (same bit order as R5) shows "5" (hex 6D) when BCD digit 0 is 5 or more, and "0" (hex 3F) otherwise. Its b and e bits are always equal. Outside FM it is dark.
- R8: Band code 1 (MW) feeds the leading position from BCD digit 3 and full digits 2,1,0 from BCD digits 2,1,0. It lights `khz_n`, and leaves `dp_n` and `tail_n` dark.
- R9: Band codes 2 and 3 (LW) feed full digits 2,1,0 from BCD digits 2,1,0, keep the leading position dark, light `khz_n`, and darken full digit 2 when its digit is zero.
- R10: In FM and MW, `one_n` (segments b and c together) is low only when its source digit is nonzero, so a zero in the top position is blanked.
- R11: In MW and LW, when the stored resolution flag is 1, full digit 0 shows "0" whatever its BCD digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Result word offered |
| in_ready | output | 1 | Word may be taken (equals freeze_n) |
| in_bcd | input | 20 | Five BCD digits, digit 0 in the low nibble |
| in_band | input | 2 | 0 FM, 1 MW, 2/3 LW |
| in_coarse | input | 1 | 1 = 10 kHz resolution on MW/LW |
| freeze_n | input | 1 | Low holds the readout |
| blank | input | 1 | High darkens the readout |
| one_n | output | 1 | Leading "1" (b and c pair), active low |
| seg_n | output | 21 | Three full digits, 7 bits each, active low |
| tail_n | output | 7 | Trailing 0/5 position, active low |
| dp_n | output | 1 | Decimal point, active low |
| mhz_n | output | 1 | MHz lamp, active low |
| khz_n | output | 1 | kHz lamp, active low |

## Verification
The stimulus covers every band: FM words with a trailing digit below and at or above five, with and without a hundreds digit, and MW and LW words with leading zeros. These separate the digit-routing shift between FM and the other bands and show where zero suppression applies. A walk of all ten digit values, plus one code above nine, covers the glyph table. Coarse-resolution words in MW and LW confirm that only the units digit is forced. Freeze and blank are exercised while new words are offered, which separates refusing a word from merely hiding it.

// File: rtl/led_disp_pkg.sv
package led_disp_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  typedef enum logic [1:0] {
    BAND_FM  = 2'd0,
    BAND_MW  = 2'd1,
    BAND_LW  = 2'd2,
    BAND_LWX = 2'd3
  } band_e;

  // active-high glyphs, bit order {g,f,e,d,c,b,a}
  localparam logic [SEG_W-1:0] GLYPH_ZERO = 7'h3F;
  localparam logic [SEG_W-1:0] GLYPH_FIVE = 7'h6D;

  function automatic logic [SEG_W-1:0] glyph_of(input logic [DIGIT_W-1:0] v);
    case (v)
      4'd0: glyph_of = 7'h3F;
      4'd1: glyph_of = 7'h06;
      4'd2: glyph_of = 7'h5B;
      4'd3: glyph_of = 7'h4F;
      4'd4: glyph_of = 7'h66;
      4'd5: glyph_of = 7'h6D;
      4'd6: glyph_of = 7'h7D;
      4'd7: glyph_of = 7'h07;
      4'd8: glyph_of = 7'h7F;
      4'd9: glyph_of = 7'h6F;
      default: glyph_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/led_frame_reg.sv
module led_frame_reg
  import led_disp_pkg::*;
#(
  parameter int BUS_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [BUS_W-1:0] bcd_in,
  input  band_e            band_in,
  input  logic             coarse_in,
  output logic [BUS_W-1:0] bcd_q,
  output band_e            band_q,
  output logic             coarse_q,
  output logic             loaded_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcd_q    <= '0;
      band_q   <= BAND_FM;
      coarse_q <= 1'b0;
      loaded_q <= 1'b0;
    end else if (take) begin
      bcd_q    <= bcd_in;
      band_q   <= band_in;
      coarse_q <= coarse_in;
      loaded_q <= 1'b1;
    end
  end
endmodule

// File: rtl/led_glyph_dec.sv
module led_glyph_dec
  import led_disp_pkg::*;
(
  input  logic [DIGIT_W-1:0] code,
  input  logic               dark,
  input  logic               force_zero,
  output logic [SEG_W-1:0]   seg_n
);
  logic [SEG_W-1:0] pat;

  always_comb begin
    pat   = force_zero ? GLYPH_ZERO : glyph_of(code);
    seg_n = dark ? '1 : ~pat;
  end
endmodule

// File: rtl/led_tail_dec.sv
module led_tail_dec
  import led_disp_pkg::*;
(
  input  logic [DIGIT_W-1:0] code,
  input  logic               lit,
  output logic [SEG_W-1:0]   seg_n
);
  logic half_up;

  always_comb begin
    half_up = (code >= DIGIT_W'(5));
    if (!lit)
      seg_n = '1;
    else
      seg_n = half_up ? ~GLYPH_FIVE : ~GLYPH_ZERO;
  end
endmodule

// File: rtl/led_disp.sv
module led_disp
  import led_disp_pkg::*;
#(
  parameter int NUM_DIGITS = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [NUM_DIGITS*DIGIT_W-1:0]     in_bcd,
  input  logic [1:0]                        in_band,
  input  logic                              in_coarse,
  input  logic                              freeze_n,
  input  logic                              blank,
  output logic                              one_n,
  output logic [(NUM_DIGITS-2)*SEG_W-1:0]   seg_n,
  output logic [SEG_W-1:0]                  tail_n,
  output logic                              dp_n,
  output logic                              mhz_n,
  output logic                              khz_n
);
  localparam int BUS_W    = NUM_DIGITS * DIGIT_W;
  localparam int FULL_CNT = NUM_DIGITS - 2;

  logic [BUS_W-1:0]   held_bcd;
  band_e              held_band;
  logic               held_coarse;
  logic               loaded;
  logic               show;
  logic               is_fm;
  logic               is_lw;
  logic [DIGIT_W-1:0] lead_code;

  assign in_ready = freeze_n;

  led_frame_reg #(.BUS_W(BUS_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (in_valid && in_ready),
    .bcd_in   (in_bcd),
    .band_in  (band_e'(in_band)),
    .coarse_in(in_coarse),
    .bcd_q    (held_bcd),
    .band_q   (held_band),
    .coarse_q (held_coarse),
    .loaded_q (loaded)
  );

  assign show  = loaded && !blank;
  assign is_fm = (held_band == BAND_FM);
  assign is_lw = (held_band == BAND_LW) || (held_band == BAND_LWX);

  // FM routes every position one BCD digit higher than the AM bands
  generate
    for (genvar gi = 0; gi < FULL_CNT; gi++) begin : g_full
      logic [DIGIT_W-1:0] code;
      logic               dark;
      logic               fz;

      assign code = is_fm ? held_bcd[(gi+1)*DIGIT_W +: DIGIT_W]
                          : held_bcd[gi*DIGIT_W +: DIGIT_W];

      if (gi == FULL_CNT - 1) begin : g_top
        assign dark = !show || (is_lw && (code == '0));
      end else begin : g_mid
        assign dark = !show;
      end

      if (gi == 0) begin : g_units
        assign fz = !is_fm && held_coarse;
      end else begin : g_other
        assign fz = 1'b0;
      end

      led_glyph_dec u_dec (
        .code      (code),
        .dark      (dark),
        .force_zero(fz),
        .seg_n     (seg_n[gi*SEG_W +: SEG_W])
      );
    end
  endgenerate

  assign lead_code = is_fm ? held_bcd[BUS_W-DIGIT_W +: DIGIT_W]
                           : held_bcd[BUS_W-2*DIGIT_W +: DIGIT_W];
  assign one_n     = !(show && !is_lw && (lead_code != '0));

  led_tail_dec u_tail (
    .code (held_bcd[DIGIT_W-1:0]),
    .lit  (show && is_fm),
    .seg_n(tail_n)
  );

  assign dp_n  = !(show && is_fm);
  assign mhz_n = !(show && is_fm);
  assign khz_n = !(show && !is_fm);
endmodule

// File: rtl/led_disp_chk.sv
module led_disp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        freeze_n,
  input logic        blank,
  input logic        one_n,
  input logic [20:0] seg_n,
  input logic [6:0]  tail_n,
  input logic        dp_n,
  input logic        mhz_n,
  input logic        khz_n
);
  logic [31:0] outs;
  assign outs = {one_n, seg_n, tail_n, dp_n, mhz_n, khz_n};

  assert_dark_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (&outs));

  assert_frozen_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_n |=> (blank || $past(blank) || $stable(outs)));

  assert_lit_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !blank) |=> (blank || !mhz_n || !khz_n));

  assert_unit_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mhz_n && !khz_n));

  assert_point_fm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_n |-> !mhz_n);

  assert_tail_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_n != 7'h7F) |-> (!mhz_n && (tail_n[1] == tail_n[4])));
endmodule

bind led_disp led_disp_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .freeze_n(freeze_n),
  .blank   (blank),
  .one_n   (one_n),
  .seg_n   (seg_n),
  .tail_n  (tail_n),
  .dp_n    (dp_n),
  .mhz_n   (mhz_n),
  .khz_n   (khz_n)
);

// File: tb/led_disp_bench.sv
module led_disp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_bcd = '0;
  logic [1:0]  in_band = '0;
  logic        in_coarse = 1'b0;
  logic        freeze_n = 1'b1;
  logic        blank = 1'b0;
  logic        one_n;
  logic [20:0] seg_n;
  logic [6:0]  tail_n;
  logic        dp_n, mhz_n, khz_n;
  logic [31:0] outs;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  led_disp u_led_disp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bcd(in_bcd), .in_band(in_band), .in_coarse(in_coarse),
    .freeze_n(freeze_n), .blank(blank), .one_n(one_n), .seg_n(seg_n),
    .tail_n(tail_n), .dp_n(dp_n), .mhz_n(mhz_n), .khz_n(khz_n)
  );

  assign outs = {one_n, seg_n, tail_n, dp_n, mhz_n, khz_n};

  function automatic logic [6:0] pat(input logic [3:0] v);
    case (v)
      4'd0: pat = 7'h3F; 4'd1: pat = 7'h06; 4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F; 4'd4: pat = 7'h66; 4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D; 4'd7: pat = 7'h07; 4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F; default: pat = 7'h00;
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [19:0] b, input logic [1:0] band,
                                        input logic co);
    logic [3:0]  d [5];
    logic [20:0] full;
    logic [6:0]  p;
    logic [3:0]  v;
    logic        fm, lw, one;
    logic [6:0]  tl;
    for (int k = 0; k < 5; k++) d[k] = b[4*k +: 4];
    fm  = (band == 2'd0);
    lw  = band[1];
    one = !(!lw && ((fm ? d[4] : d[3]) != 4'd0));
    for (int i = 0; i < 3; i++) begin
      v = fm ? d[i+1] : d[i];
      p = pat(v);
      if (!fm && co && i == 0) p = pat(4'd0);
      if (lw && i == 2 && v == 4'd0) p = 7'h00;
      full[7*i +: 7] = ~p;
    end
    tl = fm ? ~((d[0] >= 4'd5) ? 7'h6D : 7'h3F) : 7'h7F;
    model = {one, full, tl, !fm, !fm, fm};
  endfunction

  function automatic logic [19:0] bcd5(input logic [3:0] a, input logic [3:0] b,
                                       input logic [3:0] c, input logic [3:0] d,
                                       input logic [3:0] e);
    bcd5 = {a, b, c, d, e};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: queue the expected readout, then offer the word
  task automatic send(input string tag, input logic [19:0] b, input logic [1:0] band,
                      input logic co);
    exp_q.push_back(model(b, band, co));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_bcd    = b;
    in_band   = band;
    in_coarse = co;
    @(posedge clk);
    while (!in_ready) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: on every transfer, compare the next readout with the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && in_valid && in_ready) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk("R2 unexpected transfer", outs, 32'hFFFF_FFFF);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, outs, e);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=%0d cycles expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    chk("R1 in_ready during reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dark after reset", outs, 32'hFFFF_FFFF);

    // FM words
    send("R6 R7 R10 FM 107.95", bcd5(1, 0, 7, 9, 5), 2'd0, 1'b0);
    send("R10 R7 FM 88.00 lead blank", bcd5(0, 8, 8, 0, 0), 2'd0, 1'b0);
    send("R7 FM 199.93 tail zero", bcd5(1, 9, 9, 9, 3), 2'd0, 1'b0);
    send("R6 R11 FM ignores coarse", bcd5(0, 9, 1, 2, 7), 2'd0, 1'b1);
    // MW words
    send("R8 R10 MW 1530", bcd5(0, 1, 5, 3, 0), 2'd1, 1'b0);
    send("R8 R10 MW 0531 lead blank", bcd5(0, 0, 5, 3, 1), 2'd1, 1'b0);
    send("R11 MW coarse 1237", bcd5(0, 1, 2, 3, 7), 2'd1, 1'b1);
    // LW words
    send("R9 LW 252", bcd5(0, 0, 2, 5, 2), 2'd2, 1'b0);
    send("R9 LW 077 hundreds blank", bcd5(0, 1, 0, 7, 7), 2'd2, 1'b0);
    send("R9 LW code 3", bcd5(0, 0, 1, 6, 4), 2'd3, 1'b0);
    send("R11 LW coarse", bcd5(0, 0, 1, 8, 3), 2'd2, 1'b1);
    // glyph walk and an illegal code
    for (int k = 0; k < 10; k++)
      send("R5 glyph walk", bcd5(0, 0, 4'(k), 4'(9 - k), 4'(k)), 2'd1, 1'b0);
    send("R5 illegal code dark", bcd5(0, 0, 3, 4'hA, 4'hF), 2'd1, 1'b0);

    // freeze: words refused, readout unchanged
    @(negedge clk);
    freeze_n = 1'b0;
    snap = outs;
    @(negedge clk);
    chk("R3 in_ready low while frozen", {31'd0, in_ready}, 32'd0);
    exp_q.push_back(model(bcd5(1, 0, 1, 1, 5), 2'd0, 1'b0));
    tag_q.push_back("R2 R3 word taken after freeze");
    in_valid = 1'b1;
    in_bcd   = bcd5(1, 0, 1, 1, 5);
    in_band  = 2'd0;
    in_coarse = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 readout held", outs, snap);
    freeze_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 in_ready back", {31'd0, in_ready}, 32'd1);
    @(negedge clk);

    // blank: dark, then the same readout returns
    snap = outs;
    blank = 1'b1;
    @(negedge clk);
    chk("R4 blank dark", outs, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    blank = 1'b0;
    @(negedge clk);
    chk("R4 readout restored", outs, snap);

    chk("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule